// File: doc/BRIEF.md
# Timing Endpoint Message Receiver

This block sits at a timing endpoint, after the line decoder, in the recovered-clock domain. One decoded symbol arrives on each clock. Each symbol is a data byte with a control-character flag and a decode-error flag. The block keeps a free-running 64-bit local time that advances once per clock. It watches the symbol stream for two kinds of message. A broadcast time message carries the master's time and is used to set or check the local counter. An addressed command is acted on only when its address byte equals the endpoint's configured address. Commands set the endpoint delay value or switch the optical return transmitter on or off.

Every message opens with the comma control character 0xBC and then a type byte. Type 0x01 is a broadcast time message: eight payload bytes follow, most significant first. The carried value is the master time during the clock in which the last payload byte is presented. Type 0x10 (set delay) and type 0x11 (transmit control) are addressed commands. Each is followed by an address byte, a length byte, and then that many payload bytes. Only the first payload byte is used. Any other type byte ends the message quietly.

Top module: `epMsgRx`

## Requirements
- R1: After reset the timestamp, the sync flag, the delay value, the transmit enable and the error count are all zero.
- R2: Outside a time load, the timestamp rises by exactly one on every clock.
- R3: When the sync flag is low, a complete time message carrying V loads the counter. In the clock after its last payload byte, the timestamp reads V+1 and the sync flag reads 1.
- R4: When the sync flag is high and V equals the local time during the last payload byte, the counter runs on undisturbed and the sync flag stays 1.
- R5: When the sync flag is high and V differs from the local time, the counter is reloaded to V+1 and the sync flag drops to 0. The next complete time message sets it again.
- R6: A set-delay command (type 0x10) with a matching address and a length of at least 1 makes the delay output equal its first payload byte. This takes effect in the clock after the last payload byte. Later payload bytes are ignored.
- R7: A transmit-control command (type 0x11) with a matching address sets the transmit enable to bit 0 of its first payload byte. This takes effect in the clock after the last payload byte.
- R8: A command whose address byte differs from the configured address has no effect on any output. So does a command whose length byte is 0.
- R9: A control character (flag set) or a decode error on any symbol after the comma and before the message ends aborts the message. The error count rises by one and no other output changes.
- R10: The error count saturates at 255.
- R11: Between messages, data bytes, non-comma control characters and decode errors are ignored. An unknown type byte ends the message without counting an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| rxData | input | 8 | Decoded byte |
| rxIsK | input | 1 | Byte is a control character |
| rxErr | input | 1 | Decoder reported a code or disparity error |
| myAddr | input | 8 | Configured endpoint address |
| timestamp | output | 64 | Local time counter |
| tsSynced | output | 1 | Local time agrees with the master |
| delayVal | output | 8 | Delay setting from the last accepted command |
| txEnable | output | 1 | Return transmitter enable |
| errCount | output | 8 | Saturating count of aborted messages |

## Verification
A parser left in the wrong state shows up at the next message boundary. Either the command that follows is not applied, or a spurious error count appears one clock after a stray control character. A wrong byte order or an off-by-one in the latency compensation appears in the first clock after a time load, as a timestamp that is not V+1. A sync flag that is stuck or cleared wrongly can be seen within one message, because the bench sends both matching and mismatching time values.

// File: rtl/epMsgPkg.sv
package epMsgPkg;
  localparam logic [7:0] COMMA_K  = 8'hBC;
  localparam logic [7:0] TYPE_TS  = 8'h01;
  localparam logic [7:0] TYPE_DLY = 8'h10;
  localparam logic [7:0] TYPE_TXC = 8'h11;

  typedef enum logic [2:0] {
    S_IDLE, S_TYPE, S_TSPAY, S_ADDR, S_LEN, S_APAY
  } parseState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tsShift;    // push payload byte into time shifter
    logic tsDone;     // last time byte present on rxData
    logic capture;    // first command payload byte present
    logic commitDly;  // apply delay now
    logic commitTx;   // apply transmit enable now
    logic errInc;     // message aborted
  } strobe_t;
endpackage

// File: rtl/epMsgCtrl.sv
module epMsgCtrl
  import epMsgPkg::*;
#(
  parameter int TS_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rxData,
  input  logic       rxIsK,
  input  logic       rxErr,
  input  logic [7:0] myAddr,
  output strobe_t    strobe
);
  localparam logic [7:0] LAST_TS = 8'(TS_BYTES - 1);

  parseState_e state, stateNext;
  logic [7:0] cnt, cntNext;
  logic addrHit, addrHitNext;
  logic kindTx, kindTxNext;
  logic firstPay, firstPayNext;
  logic bad;

  assign bad = rxIsK | rxErr;

  always_comb begin
    stateNext    = state;
    cntNext      = cnt;
    addrHitNext  = addrHit;
    kindTxNext   = kindTx;
    firstPayNext = firstPay;
    strobe       = '0;
    if (state != S_IDLE && bad) begin
      strobe.errInc = 1'b1;
      stateNext     = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (rxIsK && !rxErr && rxData == COMMA_K) stateNext = S_TYPE;
        S_TYPE: begin
          cntNext = '0;
          if (rxData == TYPE_TS) stateNext = S_TSPAY;
          else if (rxData == TYPE_DLY || rxData == TYPE_TXC) begin
            kindTxNext = (rxData == TYPE_TXC);
            stateNext  = S_ADDR;
          end else stateNext = S_IDLE;
        end
        S_TSPAY: begin
          strobe.tsShift = 1'b1;
          cntNext = cnt + 8'd1;
          if (cnt == LAST_TS) begin
            strobe.tsDone = 1'b1;
            stateNext     = S_IDLE;
          end
        end
        S_ADDR: begin
          addrHitNext = (rxData == myAddr);
          stateNext   = S_LEN;
        end
        S_LEN: begin
          cntNext      = rxData;
          firstPayNext = 1'b1;
          stateNext    = (rxData == 8'd0) ? S_IDLE : S_APAY;
        end
        S_APAY: begin
          strobe.capture = firstPay;
          firstPayNext   = 1'b0;
          cntNext        = cnt - 8'd1;
          if (cnt == 8'd1) begin
            strobe.commitDly = addrHit & ~kindTx;
            strobe.commitTx  = addrHit & kindTx;
            stateNext        = S_IDLE;
          end
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      addrHit  <= 1'b0;
      kindTx   <= 1'b0;
      firstPay <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      addrHit  <= addrHitNext;
      kindTx   <= kindTxNext;
      firstPay <= firstPayNext;
    end
  end

  // R9: a flagged symbol inside a message returns the parser to idle
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && (rxIsK || rxErr)) |=> (state == S_IDLE));
  // R11: nothing is counted while waiting for a comma
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !strobe.errInc);
endmodule

// File: rtl/epMsgData.sv
module epMsgData
  import epMsgPkg::*;
#(
  parameter int TS_W  = 64,
  parameter int DLY_W = 8,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rxData,
  input  strobe_t          strobe,
  output logic [TS_W-1:0]  timestamp,
  output logic             tsSynced,
  output logic [DLY_W-1:0] delayVal,
  output logic             txEnable,
  output logic [ERR_W-1:0] errCount
);
  localparam int SH_W = TS_W - 8;

  logic [SH_W-1:0] shiftQ;
  logic [TS_W-1:0] rxFull;
  logic [7:0]      stageQ, commitVal;
  logic            tsLoad;

  assign rxFull    = {shiftQ, rxData};
  assign commitVal = strobe.capture ? rxData : stageQ;
  assign tsLoad    = strobe.tsDone && (!tsSynced || rxFull != timestamp);

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ    <= '0;
      stageQ    <= '0;
      timestamp <= '0;
      tsSynced  <= 1'b0;
      delayVal  <= '0;
      txEnable  <= 1'b0;
      errCount  <= '0;
    end else begin
      if (strobe.tsShift) shiftQ <= rxFull[SH_W-1:0];
      if (strobe.capture) stageQ <= rxData;
      // one clock of parse latency is folded into the load value
      timestamp <= tsLoad ? rxFull + TS_W'(1) : timestamp + TS_W'(1);
      if (tsLoad) tsSynced <= !tsSynced;
      if (strobe.commitDly) delayVal <= commitVal[DLY_W-1:0];
      if (strobe.commitTx)  txEnable <= commitVal[0];
      if (strobe.errInc && errCount != '1) errCount <= errCount + ERR_W'(1);
    end
  end

  p_ts_step_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.tsDone |=> timestamp == $past(timestamp) + TS_W'(1));
  p_first_sync_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.tsDone && !tsSynced) |=> tsSynced);
  p_dly_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe.commitDly |=> $stable(delayVal));
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobe.commitTx |=> $stable(txEnable));
  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.errInc |=> $stable(errCount));
  p_err_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (errCount == '1) |=> (errCount == '1));
endmodule

// File: rtl/epMsgRx.sv
module epMsgRx
  import epMsgPkg::*;
#(
  parameter int TS_W  = 64,
  parameter int DLY_W = 8,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rxData,
  input  logic             rxIsK,
  input  logic             rxErr,
  input  logic [7:0]       myAddr,
  output logic [TS_W-1:0]  timestamp,
  output logic             tsSynced,
  output logic [DLY_W-1:0] delayVal,
  output logic             txEnable,
  output logic [ERR_W-1:0] errCount
);
  localparam int TS_BYTES = TS_W / 8;

  strobe_t strobe;

  epMsgCtrl #(.TS_BYTES(TS_BYTES)) ctrl_i (
    .clk(clk), .rst(rst), .rxData(rxData), .rxIsK(rxIsK), .rxErr(rxErr),
    .myAddr(myAddr), .strobe(strobe)
  );

  epMsgData #(.TS_W(TS_W), .DLY_W(DLY_W), .ERR_W(ERR_W)) data_i (
    .clk(clk), .rst(rst), .rxData(rxData), .strobe(strobe),
    .timestamp(timestamp), .tsSynced(tsSynced), .delayVal(delayVal),
    .txEnable(txEnable), .errCount(errCount)
  );
endmodule

// File: tb/epMsgRx_tb_top.sv
`timescale 1ns/1ps
module epMsgRx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rxData = 8'h00;
  logic rxIsK = 1'b0;
  logic rxErr = 1'b0;
  logic [7:0] myAddr = 8'h3C;
  logic [63:0] timestamp;
  logic tsSynced;
  logic [7:0] delayVal;
  logic txEnable;
  logic [7:0] errCount;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  epMsgRx dut_i (
    .clk(clk), .rst(rst), .rxData(rxData), .rxIsK(rxIsK), .rxErr(rxErr),
    .myAddr(myAddr), .timestamp(timestamp), .tsSynced(tsSynced),
    .delayVal(delayVal), .txEnable(txEnable), .errCount(errCount)
  );

  // type, addr, len, first payload, expected delay, expected tx enable
  localparam logic [40:0] VEC [8] = '{
    {8'h10, 8'h3C, 8'd1, 8'h25, 8'h25, 1'b0},  // R6
    {8'h11, 8'h3C, 8'd1, 8'h01, 8'h25, 1'b1},  // R7
    {8'h10, 8'h3D, 8'd1, 8'h77, 8'h25, 1'b1},  // R8 address miss
    {8'h10, 8'h3C, 8'd3, 8'h40, 8'h40, 1'b1},  // R6 extra bytes
    {8'h11, 8'h3C, 8'd2, 8'h00, 8'h40, 1'b0},  // R7 off
    {8'h10, 8'h3C, 8'd0, 8'h99, 8'h40, 1'b0},  // R8 zero length
    {8'h11, 8'h3D, 8'd1, 8'h01, 8'h40, 1'b0},  // R8 address miss
    {8'h11, 8'h3C, 8'd1, 8'h03, 8'h40, 1'b1}   // R7 bit 0 only
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sym(input logic [7:0] d, input logic k, input logic e);
    @(negedge clk);
    rxData = d; rxIsK = k; rxErr = e;
  endtask

  task automatic idle();
    sym(8'h00, 1'b0, 1'b0);
  endtask

  task automatic sendCmd(input logic [7:0] typ, input logic [7:0] addr, input logic [7:0] len, input logic [7:0] val);
    sym(8'hBC, 1'b1, 1'b0);
    sym(typ, 1'b0, 1'b0);
    sym(addr, 1'b0, 1'b0);
    sym(len, 1'b0, 1'b0);
    for (int i = 0; i < int'(len); i++) sym((i == 0) ? val : 8'hAA, 1'b0, 1'b0);
    idle();
  endtask

  // value is local time at last byte plus delta
  task automatic sendTs(input logic [63:0] delta, output logic [63:0] v);
    logic [63:0] t0;
    sym(8'hBC, 1'b1, 1'b0);
    t0 = timestamp;
    v = t0 + 64'd9 + delta;
    sym(8'h01, 1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) sym(v[i*8 +: 8], 1'b0, 1'b0);
    idle();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      finish();
    end
  end

  initial begin
    logic [63:0] v, a;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(timestamp == 0 && !tsSynced && delayVal == 0 && !txEnable && errCount == 0,
          "R1 reset", {tsSynced, txEnable, delayVal, errCount}, 0);
    rst = 1'b0;
    idle();
    a = timestamp;
    repeat (5) idle();
    check(timestamp == a + 5, "R2 count", timestamp, a + 5);

    // R3 first load
    sendTs(64'd5000, v);
    check(timestamp == v + 1, "R3 load value", timestamp, v + 1);
    check(tsSynced == 1'b1, "R3 sync set", tsSynced, 1);
    // R4 matching check
    sendTs(64'd0, v);
    check(timestamp == v + 1, "R4 run on", timestamp, v + 1);
    check(tsSynced == 1'b1, "R4 sync kept", tsSynced, 1);
    // R5 mismatch reloads and clears
    sendTs(64'd1000, v);
    check(timestamp == v + 1, "R5 reload", timestamp, v + 1);
    check(tsSynced == 1'b0, "R5 sync cleared", tsSynced, 0);
    sendTs(64'd77, v);
    check(timestamp == v + 1 && tsSynced, "R5 resync", {tsSynced, timestamp}, {1'b1, v + 64'd1});

    // command table
    for (int n = 0; n < 8; n++) begin
      sendCmd(VEC[n][40:33], VEC[n][32:25], VEC[n][24:17], VEC[n][16:9]);
      check(delayVal == VEC[n][8:1], "R6/R8 delay", delayVal, VEC[n][8:1]);
      check(txEnable == VEC[n][0], "R7/R8 txen", txEnable, VEC[n][0]);
    end
    check(errCount == 0, "R8 no errors", errCount, 0);

    // R9 abort by control char inside a command
    sym(8'hBC, 1'b1, 1'b0); sym(8'h10, 1'b0, 1'b0); sym(8'h3C, 1'b0, 1'b0);
    sym(8'h02, 1'b0, 1'b0); sym(8'h55, 1'b0, 1'b0); sym(8'h1C, 1'b1, 1'b0);
    sym(8'h66, 1'b0, 1'b0); idle();
    check(errCount == 1, "R9 count k abort", errCount, 1);
    check(delayVal == 8'h40, "R9 delay untouched", delayVal, 8'h40);
    // R9 abort by decode error inside a time message
    sym(8'hBC, 1'b1, 1'b0); sym(8'h01, 1'b0, 1'b0);
    sym(8'hFF, 1'b0, 1'b0); sym(8'hFF, 1'b0, 1'b0); sym(8'hFF, 1'b0, 1'b0);
    sym(8'h00, 1'b0, 1'b1);
    a = timestamp;
    repeat (8) idle();
    check(errCount == 2, "R9 count err abort", errCount, 2);
    check(timestamp == a + 8 && tsSynced, "R9 time untouched", timestamp, a + 8);

    // R11 idle noise and unknown type
    sym(8'h01, 1'b0, 1'b0); sym(8'h1C, 1'b1, 1'b0); sym(8'hBC, 1'b0, 1'b1);
    sym(8'h10, 1'b0, 1'b0); sym(8'h3C, 1'b0, 1'b0);
    sym(8'hBC, 1'b1, 1'b0); sym(8'h77, 1'b0, 1'b0); sym(8'h3C, 1'b0, 1'b0);
    sym(8'h01, 1'b0, 1'b0); sym(8'h12, 1'b0, 1'b0); idle();
    check(errCount == 2, "R11 no count", errCount, 2);
    check(delayVal == 8'h40 && txEnable, "R11 no effect", {txEnable, delayVal}, {1'b1, 8'h40});

    // R10 saturation
    for (int n = 0; n < 300; n++) begin
      sym(8'hBC, 1'b1, 1'b0); sym(8'h00, 1'b0, 1'b1);
    end
    idle();
    check(errCount == 8'hFF, "R10 saturate", errCount, 8'hFF);
    finish();
  end
endmodule